// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Master

This block drives a three-wire serial EEPROM (chip select, serial clock, data to the memory, data from the memory) at bit level. A host asks for a single 16-bit word read or write with a simple request/acknowledge handshake. The block then clocks out the opcode, address and data one bit at a time, and it paces every bit phase with a clock divider.

A read sends the read opcode and the address, then clocks in sixteen data bits. A write is a full protected sequence of four steps: an erase/write unlock command, the write command itself, a poll of the memory's ready line, and a lock command. The address is either 6 or 8 bits wide, chosen per request. If the memory never reports ready, the block raises a timeout flag. It still locks the memory before it acknowledges.

Top module: `mw_eeprom_master`

## Requirements
- R1: While rst_ni is low and after reset, ee_cs_o, ee_sk_o, ee_di_o, ack_o and timeout_o are all 0.
- R2: Each bit is sent most significant first in three phases of CLK_DIV clock cycles each: ee_di_o is set with ee_sk_o low, then ee_sk_o is high, then ee_sk_o is low. ee_di_o does not change while ee_sk_o is high, and ee_sk_o is never high while ee_cs_o is low.
- R3: A read (we_i=0) sends opcode 110 and the address, then gives 16 further clock pulses. On each of them ee_do_i is sampled while ee_sk_o is high, and the bits fill rdata_o most significant first. rdata_o is valid when ack_o is high.
- R4: With addr_w8_i=1 the address field is addr_i[7:0]. With addr_w8_i=0 it is addr_i[5:0], and addr_i[7:6] are ignored.
- R5: A write (we_i=1) first sends the unlock command: 100, then an address field whose two top bits are 1 and whose other bits are 0. ee_cs_o then goes low for exactly CLK_DIV cycles. Next the block sends 101, the address and the 16 bits of wdata_i. ee_cs_o then goes low again for exactly CLK_DIV cycles.
- R6: After the write command, ee_cs_o is held high while ee_do_i is polled. The first sample is taken CLK_DIV cycles after ee_cs_o rises, and each further sample POLL_GAP*CLK_DIV cycles later. A sampled 1 ends the poll at once.
- R7: If POLL_MAX samples all read 0, the poll ends on the last of them and timeout_o is 1 while ack_o is high. The lock command is still sent.
- R8: After the poll, ee_cs_o goes low for exactly CLK_DIV cycles. The block then sends the lock command (100 followed by an all-zero address field), drives ee_cs_o low for CLK_DIV cycles, and acknowledges.
- R9: A request is taken only when the block is idle. ack_o is a single-cycle pulse with ee_cs_o, ee_sk_o and ee_di_o low. timeout_o is 0 at the acknowledge of a read, and at the acknowledge of a write whose poll saw ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request; hold until ack_o |
| we_i | input | 1 | 1 = write word, 0 = read word |
| addr_i | input | 8 | Word address |
| addr_w8_i | input | 1 | 1 = 8-bit address field, 0 = 6-bit |
| wdata_i | input | 16 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, valid with ack_o |
| timeout_o | output | 1 | Ready not seen within the poll limit |
| ee_cs_o | output | 1 | Memory chip select |
| ee_sk_o | output | 1 | Memory serial clock |
| ee_di_o | output | 1 | Serial data to the memory |
| ee_do_i | input | 1 | Serial data and ready from the memory |

## Verification
The hardest conditions to reach are the ends of the ready poll. One is a memory that is ready on the very first sample. The other is a memory that never becomes ready, so the poll must run to exactly POLL_MAX samples and then still lock the memory. The bench contains a behavioural memory whose busy time is set per transaction: zero, a few dozen cycles, or effectively forever. The bench shrinks POLL_MAX and POLL_GAP through parameters and measures the chip-select high time of the poll against the exact length that the sample spacing predicts. Because the memory model stores a word only while it is unlocked, and logs every decoded command in order, a wrong unlock pattern or a missing lock shows up in the stored contents and in the log.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int unsigned OP_W    = 3;
  localparam int unsigned AW_MIN  = 6;
  localparam int unsigned AW_MAX  = 8;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned FRAME_W = OP_W + AW_MAX + DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    OP_LOCKCTL = 3'b100,
    OP_WRITE   = 3'b101,
    OP_READ    = 3'b110
  } mw_op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SET,
    PH_HIGH,
    PH_LOW
  } mw_ph_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_UNLOCK,
    S_GAP_A,
    S_WRITE,
    S_GAP_B,
    S_POLL,
    S_GAP_C,
    S_LOCK,
    S_GAP_D,
    S_READ,
    S_DONE
  } mw_state_e;

  function automatic logic [CNT_W-1:0] mw_addr_bits(input logic aw8);
    return aw8 ? CNT_W'(AW_MAX) : CNT_W'(AW_MIN);
  endfunction

  // left-aligned frame: opcode, address field, data
  function automatic logic [FRAME_W-1:0] mw_frame(input mw_op_e op,
                                                  input logic [AW_MAX-1:0] field,
                                                  input logic aw8,
                                                  input logic [DATA_W-1:0] data);
    if (aw8) return {op, field, data};
    return {op, field[AW_MIN-1:0], data, {(AW_MAX-AW_MIN){1'b0}}};
  endfunction
endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mw_bit_shifter.sv
module mw_bit_shifter
  import mw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               ld_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   ntx_i,
  input  logic [CNT_W-1:0]   nrx_i,
  input  logic               do_i,
  output logic               di_o,
  output logic               sk_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  rdata_o
);
  mw_ph_e             ph_q;
  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   tx_q, rx_q;
  logic               done_q;
  logic [DATA_W-1:0]  rd_q;

  assign di_o    = (ph_q != PH_IDLE) && (tx_q != '0) && sr_q[FRAME_W-1];
  assign sk_o    = (ph_q == PH_HIGH);
  assign done_o  = done_q;
  assign rdata_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      sr_q   <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
      rd_q   <= '0;
    end else if (ld_i) begin
      ph_q   <= PH_SET;
      sr_q   <= frame_i;
      tx_q   <= ntx_i;
      rx_q   <= nrx_i;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (ph_q)
          PH_SET:  ph_q <= PH_HIGH;
          PH_HIGH: begin
            ph_q <= PH_LOW;
            if (tx_q == '0) rd_q <= {rd_q[DATA_W-2:0], do_i};
          end
          PH_LOW: begin
            if (tx_q != '0) begin
              sr_q <= sr_q << 1;
              tx_q <= tx_q - 1'b1;
              if (tx_q == CNT_W'(1) && rx_q == '0) begin
                ph_q   <= PH_IDLE;
                done_q <= 1'b1;
              end else begin
                ph_q <= PH_SET;
              end
            end else begin
              rx_q <= rx_q - 1'b1;
              if (rx_q == CNT_W'(1)) begin
                ph_q   <= PH_IDLE;
                done_q <= 1'b1;
              end else begin
                ph_q <= PH_SET;
              end
            end
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
#(
  parameter int unsigned POLL_MAX = 1000,
  parameter int unsigned POLL_GAP = 50
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW_MAX-1:0]  addr_i,
  input  logic               aw8_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               tick_i,
  input  logic               sh_done_i,
  input  logic               do_i,
  output logic               ack_o,
  output logic               timeout_o,
  output logic               cs_o,
  output logic               clr_o,
  output logic               ld_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   ntx_o,
  output logic [CNT_W-1:0]   nrx_o
);
  localparam int unsigned SW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam int unsigned WW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;

  mw_state_e          state_q, state_d;
  logic               we_q, aw8_q, to_q;
  logic [AW_MAX-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [SW-1:0]      scnt_q;
  logic [WW-1:0]      wcnt_q;
  logic [CNT_W-1:0]   abits;
  logic [AW_MAX-1:0]  unlock_field;
  logic               poll_smp, poll_last;

  assign abits        = mw_addr_bits(aw8_q);
  assign unlock_field = AW_MAX'(2'b11) << (abits - CNT_W'(2));
  assign poll_smp     = (state_q == S_POLL) && tick_i && (wcnt_q == '0);
  assign poll_last    = (scnt_q == SW'(POLL_MAX - 1));

  always_comb begin
    state_d = state_q;
    ld_o    = 1'b0;
    frame_o = '0;
    ntx_o   = '0;
    nrx_o   = '0;
    unique case (state_q)
      S_IDLE:  if (req_i) state_d = S_START;
      S_START: begin
        ld_o  = 1'b1;
        ntx_o = CNT_W'(OP_W) + abits;
        if (we_q) begin
          state_d = S_UNLOCK;
          frame_o = mw_frame(OP_LOCKCTL, unlock_field, aw8_q, '0);
        end else begin
          state_d = S_READ;
          frame_o = mw_frame(OP_READ, addr_q, aw8_q, '0);
          nrx_o   = CNT_W'(DATA_W);
        end
      end
      S_UNLOCK: if (sh_done_i) state_d = S_GAP_A;
      S_GAP_A: if (tick_i) begin
        state_d = S_WRITE;
        ld_o    = 1'b1;
        frame_o = mw_frame(OP_WRITE, addr_q, aw8_q, wdata_q);
        ntx_o   = CNT_W'(OP_W + DATA_W) + abits;
      end
      S_WRITE: if (sh_done_i) state_d = S_GAP_B;
      S_GAP_B: if (tick_i) state_d = S_POLL;
      S_POLL:  if (poll_smp && (do_i || poll_last)) state_d = S_GAP_C;
      S_GAP_C: if (tick_i) begin
        state_d = S_LOCK;
        ld_o    = 1'b1;
        frame_o = mw_frame(OP_LOCKCTL, '0, aw8_q, '0);
        ntx_o   = CNT_W'(OP_W) + abits;
      end
      S_LOCK:  if (sh_done_i) state_d = S_GAP_D;
      S_READ:  if (sh_done_i) state_d = S_GAP_D;
      S_GAP_D: if (tick_i) state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign clr_o     = (state_d != state_q);
  assign ack_o     = (state_q == S_DONE);
  assign timeout_o = to_q;
  assign cs_o      = (state_q == S_UNLOCK) || (state_q == S_WRITE) ||
                     (state_q == S_POLL)   || (state_q == S_LOCK)  ||
                     (state_q == S_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      we_q    <= 1'b0;
      aw8_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      to_q    <= 1'b0;
      scnt_q  <= '0;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && req_i) begin
        we_q    <= we_i;
        aw8_q   <= aw8_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        to_q    <= 1'b0;
      end
      if (state_q == S_GAP_B && tick_i) begin
        scnt_q <= '0;
        wcnt_q <= '0;
      end else if (state_q == S_POLL && tick_i) begin
        if (wcnt_q != '0) begin
          wcnt_q <= wcnt_q - 1'b1;
        end else if (!do_i) begin
          if (poll_last) begin
            to_q <= 1'b1;
          end else begin
            scnt_q <= scnt_q + 1'b1;
            wcnt_q <= WW'(POLL_GAP - 1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
  import mw_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 4,
  parameter int unsigned POLL_MAX = 1000,
  parameter int unsigned POLL_GAP = 50
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic        addr_w8_i,
  input  logic [15:0] wdata_i,
  output logic        ack_o,
  output logic [15:0] rdata_o,
  output logic        timeout_o,
  output logic        ee_cs_o,
  output logic        ee_sk_o,
  output logic        ee_di_o,
  input  logic        ee_do_i
);
  logic               tick, clr, ld, sh_done, cs, sk, di;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   ntx, nrx;

  mw_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .tick_o(tick)
  );

  mw_seq #(.POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .aw8_i    (addr_w8_i),
    .wdata_i  (wdata_i),
    .tick_i   (tick),
    .sh_done_i(sh_done),
    .do_i     (ee_do_i),
    .ack_o    (ack_o),
    .timeout_o(timeout_o),
    .cs_o     (cs),
    .clr_o    (clr),
    .ld_o     (ld),
    .frame_o  (frame),
    .ntx_o    (ntx),
    .nrx_o    (nrx)
  );

  mw_bit_shifter u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .ld_i   (ld),
    .frame_i(frame),
    .ntx_i  (ntx),
    .nrx_i  (nrx),
    .do_i   (ee_do_i),
    .di_o   (di),
    .sk_o   (sk),
    .done_o (sh_done),
    .rdata_o(rdata_o)
  );

  assign ee_cs_o = cs;
  assign ee_sk_o = sk & cs;
  assign ee_di_o = di & cs;
endmodule

// File: rtl/mw_eeprom_master_chk.sv
module mw_eeprom_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ack_o,
  input logic timeout_o,
  input logic ee_cs_o,
  input logic ee_sk_o,
  input logic ee_di_o
);
  // R2: clock only inside a selected frame
  a_r2_sk_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> ee_cs_o);

  // R2: data held while clock high
  a_r2_di_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o));

  // R2: select never drops mid-pulse
  a_r2_cs_fall_sk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ee_cs_o) |-> !ee_sk_o);

  // R9: single-cycle acknowledge
  a_r9_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R9: bus quiet at acknowledge
  a_r9_ack_bus_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (!ee_cs_o && !ee_sk_o && !ee_di_o));

  // R7: timeout raised exactly as the poll ends
  a_r7_timeout_at_poll_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $fell(ee_cs_o));
endmodule

bind mw_eeprom_master mw_eeprom_master_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ack_o    (ack_o),
  .timeout_o(timeout_o),
  .ee_cs_o  (ee_cs_o),
  .ee_sk_o  (ee_sk_o),
  .ee_di_o  (ee_di_o)
);

// File: tb/mw_eeprom_master_tb.sv
module mw_eeprom_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;
  localparam int PM  = 6;
  localparam int PG  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, aw8 = 1'b0;
  logic [7:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ack, timeout, cs, sk, di;
  logic [15:0] rdata;
  logic do_r = 1'b1;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_master #(.CLK_DIV(DIV), .POLL_MAX(PM), .POLL_GAP(PG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .addr_w8_i(aw8), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .timeout_o(timeout), .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(do_r)
  );

  function automatic void chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endfunction

  // behavioural memory model
  logic [15:0] mem [256];
  int bits [64];
  int nbits = 0;
  bit cur_aw8 = 0, unlocked = 0, rd_active = 0, gap_armed = 0;
  bit sk_prev = 0, cs_prev = 0, di_prev = 0;
  int busy_cfg = 0, busy_left = 0, rd_addr = 0, rd_idx = 0;
  int sk_len = 0, cs_lo_len = 0, cs_hi_len = 0, poll_len = 0;
  int log_code = 0;

  function automatic int field(input int start, input int len);
    int v = 0;
    for (int i = 0; i < len; i++) v = (v << 1) | bits[start + i];
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      nbits = 0; sk_prev = 0; cs_prev = 0; di_prev = 0;
      sk_len = 0; cs_lo_len = 0; cs_hi_len = 0; gap_armed = 0; rd_active = 0;
    end else begin
      automatic int aw = cur_aw8 ? 8 : 6;
      if (busy_left > 0) busy_left--;
      if (sk && !cs) chk(0, "R2 sk without cs", 1, 0);
      if (sk && sk_prev && di != di_prev) chk(0, "R2 di moved while sk high", di, di_prev);
      if (ack) gap_armed = 0;
      // rising clock: capture / present data
      if (sk && !sk_prev) begin
        if (rd_active) begin
          do_r = mem[rd_addr][15 - rd_idx];
          rd_idx++;
        end
        if (nbits < 64) bits[nbits] = di;
        nbits++;
        if (!rd_active && nbits == 3 + aw && field(0, 3) == 3'b110) begin
          rd_active = 1; rd_addr = field(3, aw); rd_idx = 0;
        end
      end
      if (sk) sk_len++;
      if (!sk && sk_prev) begin
        chk(sk_len == DIV, "R2 sk high width", sk_len, DIV);
        sk_len = 0;
      end
      if (cs) cs_hi_len++; else cs_lo_len++;
      if (cs && !cs_prev) begin
        if (gap_armed) chk(cs_lo_len == DIV, "R5 R8 cs low gap", cs_lo_len, DIV);
        cs_hi_len = 1;
      end
      if (!cs && cs_prev) begin
        automatic int op = (nbits >= 3) ? field(0, 3) : 0;
        automatic int k = 9;
        if (nbits == 0) begin
          k = 5; poll_len = cs_hi_len;
        end else if (nbits == 3 + aw && op == 3'b100) begin
          automatic int f = field(3, aw);
          if (f == 0) begin k = 3; unlocked = 0; end
          else if (f == (3 << (aw - 2))) begin k = 1; unlocked = 1; end
        end else if (nbits == 3 + aw + 16 && op == 3'b101) begin
          k = 2;
          if (unlocked) mem[field(3, aw)] = 16'(field(3 + aw, 16));
          busy_left = busy_cfg;
        end else if (nbits == 3 + aw + 16 && op == 3'b110) begin
          k = 4;
        end
        log_code = log_code * 10 + k;
        nbits = 0; rd_active = 0; gap_armed = 1; cs_lo_len = 1;
      end
      if (!rd_active) do_r = (busy_left == 0);
      sk_prev = sk; cs_prev = cs; di_prev = di;
    end
  end

  task automatic txn(input bit w, input logic [7:0] a, input logic [15:0] d,
                     input bit a8, input int busy,
                     output logic [15:0] rd, output bit to_flag);
    @(negedge clk);
    cur_aw8 = a8; busy_cfg = busy; log_code = 0;
    req = 1; we = w; addr = a; wdata = d; aw8 = a8;
    do @(negedge clk); while (!ack);
    rd = rdata; to_flag = timeout;
    req = 0;
    @(negedge clk);
    chk(!ack, "R9 ack single cycle", ack, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R9 watchdog expired actual=hang expected=ack");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    bit to;
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 16'h0101) ^ 16'h5A3C);
    repeat (3) @(negedge clk);
    chk({cs, sk, di, ack, timeout} == 5'b0, "R1 outputs in reset", {cs, sk, di, ack, timeout}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk({cs, sk, di, ack, timeout} == 5'b0, "R1 outputs after reset", {cs, sk, di, ack, timeout}, 0);

    // R3 R4: 8-bit read
    txn(0, 8'hA5, 16'h0, 1, 0, rd, to);
    chk(rd == mem[8'hA5], "R3 read data aw8", rd, mem[8'hA5]);
    chk(log_code == 4, "R3 read command frame", log_code, 4);
    chk(!to, "R9 no timeout on read", to, 0);

    // R4: 6-bit read, upper address bits ignored
    txn(0, 8'hEB, 16'h0, 0, 0, rd, to);
    chk(rd == mem[8'h2B], "R4 read aw6 ignores addr[7:6]", rd, mem[8'h2B]);
    chk(log_code == 4, "R4 aw6 frame length", log_code, 4);

    // R5 R6 R8: write, memory ready immediately
    txn(1, 8'h3C, 16'hBEEF, 1, 0, rd, to);
    chk(log_code == 1253, "R5 R8 write command order", log_code, 1253);
    chk(mem[8'h3C] == 16'hBEEF, "R5 word stored", mem[8'h3C], 16'hBEEF);
    chk(poll_len == DIV, "R6 first poll sample", poll_len, DIV);
    chk(!to, "R9 no timeout when ready", to, 0);
    chk(!unlocked, "R8 memory relocked", unlocked, 0);

    // R6: write, 6-bit, memory busy for a while
    txn(1, 8'h2B, 16'h1234, 0, 40, rd, to);
    chk(log_code == 1253, "R5 aw6 write command order", log_code, 1253);
    chk(mem[8'h2B] == 16'h1234, "R5 aw6 word stored", mem[8'h2B], 16'h1234);
    chk(poll_len > DIV && poll_len < DIV * (1 + (PM - 1) * PG), "R6 poll ends on ready",
        poll_len, DIV * (1 + (PM - 1) * PG));
    chk(!to, "R6 no timeout after busy", to, 0);

    // R7: memory never ready
    txn(1, 8'h77, 16'hCAFE, 1, 1000000, rd, to);
    chk(to, "R7 timeout flag", to, 1);
    chk(poll_len == DIV * (1 + (PM - 1) * PG), "R7 poll length at limit",
        poll_len, DIV * (1 + (PM - 1) * PG));
    chk(log_code == 1253, "R7 lock still sent", log_code, 1253);
    chk(!unlocked, "R8 relocked after timeout", unlocked, 0);

    // R9: timeout clears on next request
    busy_left = 0;
    repeat (2) @(negedge clk);
    txn(1, 8'h10, 16'h0F0F, 1, 0, rd, to);
    chk(!to, "R9 timeout cleared", to, 0);

    // R3: read back written words
    txn(0, 8'h2B, 16'h0, 0, 0, rd, to);
    chk(rd == 16'h1234, "R3 read back aw6", rd, 16'h1234);
    txn(0, 8'h3C, 16'h0, 1, 0, rd, to);
    chk(rd == 16'hBEEF, "R3 read back aw8", rd, 16'hBEEF);

    repeat (5) @(negedge clk);
    chk({cs, sk, ack} == 3'b0, "R9 idle after last ack", {cs, sk, ack}, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule